// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register interface of a serial port. A processor reaches it through a simple bus: one request per cycle, a word address, a write enable and 32-bit write data. Read data comes back registered one cycle later. Received bytes arrive as a byte with a valid strobe and are queued in a 16-entry FIFO. A write to the transmit data word sends its low byte out as a one-cycle strobe.

Software drains the receive queue through two status windows. One window shows the oldest byte and leaves the queue alone. The other window shows the same word and removes that byte. The interrupt logic keeps latched raw event bits, a mask, a write-one-to-clear acknowledge word and a masked view. The single interrupt line is the OR of the masked bits. After each transmit-data write, the next acknowledge cannot clear the transmit-done bit (bit 0). That acknowledge consumes the pending-transmit flag instead.

Top module: `uart_reg_front`

## Requirements
- R1: After reset, every readable word reads 0, except the two status windows, which read 0x0140_0000. The interrupt output is low.
- R2: A status word holds the oldest queued byte in bits 7:0 and has bit 16 set when the queue is non-empty. Bits 22 and 24 always read 1, and all other bits read 0. When the queue is empty, bits 7:0 read 0.
- R3: A read of the peek window (word 9, byte offset 0x24) returns the status word and leaves the queue unchanged.
- R4: A read of the pop window (word 8, byte offset 0x20) returns the status word and removes the oldest byte. On an empty queue it returns bit 16 clear and changes nothing.
- R5: The queue returns bytes in arrival order and holds 16 of them. A byte that arrives while the queue is full is discarded.
- R6: A received byte is accepted only while bit 3 of the receive control word (word 2) is 1. Otherwise it is discarded.
- R7: Raw interrupt bit 3 (word 13) reads 1 exactly when the queue is non-empty. Writes to that bit have no effect.
- R8: A write to the transmit data word (word 7) drives its low byte on `tx_byte` with `tx_valid` high for exactly the following cycle. It sets raw interrupt bits 0 and 1 and marks a transmit pending.
- R9: A write to the acknowledge word (word 12) clears each raw bit that is 1 in the value. While a transmit is pending, bit 0 of that value is treated as 0 and the pending flag is cleared. The acknowledge word reads back the value actually applied.
- R10: The masked word (word 14) reads raw AND mask (mask is word 11), and writes to it are ignored. `irq` is high exactly when that value is non-zero.
- R11: Words 0 to 7, 10, 11 and 13 return the last value written, with word 13 subject to R7.
- R12: Read data is valid, and `bus_rvalid` is high, in the cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 4 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte strobe |
| tx_byte | output | 8 | Byte to transmit |
| tx_valid | output | 1 | One-cycle transmit strobe |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check that the queue count never exceeds capacity. They also check that pops on an empty queue and bytes arriving while receive is disabled leave the count unchanged, and that a transmit write always leaves raw bits 0 and 1 set. They check that an acknowledge made while a transmit is pending spares bit 0, and that every read gets its valid strobe. Only the bench scenarios can show the rest: the byte order through the queue, the exact status word layout, that peek and pop give the same result, and the masked value and interrupt level over a sweep of raw and mask patterns.

// File: rtl/urf_pkg.sv
package urf_pkg;
  localparam int WORD_AW    = 4;
  localparam int NUM_WORDS  = 15;

  localparam logic [WORD_AW-1:0] W_TXCTRL = 4'd0;
  localparam logic [WORD_AW-1:0] W_TXDMA  = 4'd1;
  localparam logic [WORD_AW-1:0] W_RXCTRL = 4'd2;
  localparam logic [WORD_AW-1:0] W_TXDATA = 4'd7;
  localparam logic [WORD_AW-1:0] W_POP    = 4'd8;
  localparam logic [WORD_AW-1:0] W_PEEK   = 4'd9;
  localparam logic [WORD_AW-1:0] W_MASK   = 4'd11;
  localparam logic [WORD_AW-1:0] W_ACK    = 4'd12;
  localparam logic [WORD_AW-1:0] W_RAW    = 4'd13;
  localparam logic [WORD_AW-1:0] W_MASKED = 4'd14;

  localparam int RX_EN_BIT   = 3;
  localparam int DAV_BIT     = 16;
  localparam int TX_IDLE_BIT = 22;
  localparam int TX_RDY_BIT  = 24;
  localparam int RAW_RX_BIT  = 3;
  localparam int RAW_TXD_BIT = 0;

  // Compose the status window word from the head byte and availability.
  function automatic logic [31:0] status_word(input logic [7:0] head, input logic avail);
    logic [31:0] w;
    w = '0;
    w[7:0]        = avail ? head : 8'h00;
    w[DAV_BIT]    = avail;
    w[TX_IDLE_BIT] = 1'b1;
    w[TX_RDY_BIT]  = 1'b1;
    return w;
  endfunction

  // Value an acknowledge write actually applies.
  function automatic logic [31:0] ack_applied(input logic [31:0] val, input logic tx_pend);
    logic [31:0] v;
    v = val;
    if (tx_pend) v[RAW_TXD_BIT] = 1'b0;
    return v;
  endfunction

  // Words that behave as plain storage.
  function automatic logic is_plain(input logic [WORD_AW-1:0] idx);
    return (idx != W_POP) && (idx != W_PEEK) && (idx != W_RAW) &&
           (idx != W_MASKED) && (idx != W_ACK) && (int'(idx) < NUM_WORDS);
  endfunction
endpackage

// File: rtl/urf_rx_fifo.sv
module urf_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic [DW-1:0]                din_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                head_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         empty_o,
  output logic                         push_ok_o,
  output logic                         pop_ok_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o   = (cnt_q == '0);
  assign push_ok_o = push_i && (cnt_q < CW'(DEPTH));
  assign pop_ok_o  = pop_i && !empty_o;
  assign head_o    = mem_q[rd_q];
  assign count_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (push_ok_o) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok_o) wr_q <= bump(wr_q);
      if (pop_ok_o)  rd_q <= bump(rd_q);
      case ({push_ok_o, pop_ok_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH) && push_i && !pop_i) |=> (cnt_q == CW'(DEPTH)));
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i && !push_i) |=> (cnt_q == '0));
endmodule

// File: rtl/urf_irq_ctrl.sv
module urf_irq_ctrl
  import urf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_evt_i,
  input  logic        ack_evt_i,
  input  logic [31:0] ack_val_i,
  input  logic        raw_wr_i,
  input  logic [31:0] raw_val_i,
  input  logic [31:0] mask_i,
  input  logic        nonempty_i,
  output logic [31:0] raw_o,
  output logic [31:0] masked_o,
  output logic [31:0] ack_eff_o,
  output logic        irq_o
);
  logic [31:0] raw_q;
  logic        pend_q;

  assign ack_eff_o = ack_applied(ack_val_i, pend_q);

  always_comb begin
    raw_o = raw_q;
    raw_o[RAW_RX_BIT] = nonempty_i;
  end

  assign masked_o = raw_o & mask_i;
  assign irq_o    = |masked_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      pend_q <= 1'b0;
    end else if (tx_evt_i) begin
      raw_q  <= raw_q | 32'h3;
      pend_q <= 1'b1;
    end else if (ack_evt_i) begin
      raw_q  <= raw_q & ~ack_eff_o;
      pend_q <= 1'b0;
    end else if (raw_wr_i) begin
      raw_q  <= raw_val_i;
    end
  end

  p_tx_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt_i |=> (raw_o[1:0] == 2'b11));
  p_ack_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt_i && pend_q) |=> (!pend_q && raw_o[0] == $past(raw_o[0])));
  p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (mask_i != '0));
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
  import urf_pkg::*;
#(
  parameter int RX_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [WORD_AW-1:0] bus_word,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  input  logic [7:0]         rx_byte,
  input  logic               rx_valid,
  output logic [7:0]         tx_byte,
  output logic               tx_valid,
  output logic               irq
);
  localparam int CW = $clog2(RX_DEPTH+1);

  logic [31:0] regs_q [NUM_WORDS];
  logic        wr_evt, rd_evt, tx_evt, ack_evt, raw_wr, pop_req, rx_push;
  logic [7:0]  head;
  logic [CW-1:0] count;
  logic        empty, push_ok, pop_ok;
  logic [31:0] raw, masked, ack_eff, rd_word;

  assign wr_evt  = bus_req && bus_we;
  assign rd_evt  = bus_req && !bus_we;
  assign tx_evt  = wr_evt && (bus_word == W_TXDATA);
  assign ack_evt = wr_evt && (bus_word == W_ACK);
  assign raw_wr  = wr_evt && (bus_word == W_RAW);
  assign pop_req = rd_evt && (bus_word == W_POP);
  assign rx_push = rx_valid && regs_q[W_RXCTRL][RX_EN_BIT];

  urf_rx_fifo #(.DEPTH(RX_DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_i(rx_push), .din_i(rx_byte), .pop_i(pop_req),
    .head_o(head), .count_o(count), .empty_o(empty),
    .push_ok_o(push_ok), .pop_ok_o(pop_ok)
  );

  urf_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n),
    .tx_evt_i(tx_evt), .ack_evt_i(ack_evt), .ack_val_i(bus_wdata),
    .raw_wr_i(raw_wr), .raw_val_i(bus_wdata), .mask_i(regs_q[W_MASK]),
    .nonempty_i(!empty), .raw_o(raw), .masked_o(masked),
    .ack_eff_o(ack_eff), .irq_o(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) regs_q[i] <= '0;
    end else if (wr_evt) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        if (bus_word == WORD_AW'(i)) begin
          if (is_plain(WORD_AW'(i)))     regs_q[i] <= bus_wdata;
          else if (WORD_AW'(i) == W_ACK) regs_q[i] <= ack_eff;
        end
      end
    end
  end

  always_comb begin
    case (bus_word)
      W_POP, W_PEEK: rd_word = status_word(head, !empty);
      W_RAW:         rd_word = raw;
      W_MASKED:      rd_word = masked;
      default:       rd_word = (int'(bus_word) < NUM_WORDS) ? regs_q[bus_word] : '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      tx_byte    <= '0;
      tx_valid   <= 1'b0;
    end else begin
      bus_rvalid <= rd_evt;
      if (rd_evt) bus_rdata <= rd_word;
      tx_valid <= tx_evt;
      if (tx_evt) tx_byte <= bus_wdata[7:0];
    end
  end

  p_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> bus_rvalid);
  p_tx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid || $past(tx_evt));
  p_rx_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !regs_q[W_RXCTRL][RX_EN_BIT] && !pop_req) |=> $stable(count));
  p_pop_only_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |-> (count != '0));
  p_push_when_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |-> (count < CW'(RX_DEPTH)));
endmodule

// File: tb/uart_reg_front_bench.sv
module uart_reg_front_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic [7:0]  tx_byte;
  logic        tx_valid, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  uart_reg_front u_uart_reg_front (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] w, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_word = w;
    @(negedge clk);
    bus_req = 1'b0;
    chk("R12 rvalid", {31'b0, bus_rvalid}, 32'h1);
    d = bus_rdata;
  endtask

  task automatic wr(input logic [3:0] w, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_word = w; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic [31:0] exp_stat(input logic [7:0] b, input logic dav);
    return 32'h0140_0000 + (dav ? (32'h0001_0000 + {24'h0, b}) : 32'h0);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, p, m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    chk("R1 irq", {31'b0, irq}, 32'h0);
    for (int w = 0; w < 15; w++) begin
      rd(4'(w), d);
      chk("R1 reset word", d, (w == 8 || w == 9) ? 32'h0140_0000 : 32'h0);
    end

    // R6: receive disabled discards
    push(8'h5A);
    rd(4'd9, d);
    chk("R6 disabled rx", d, exp_stat(8'h00, 1'b0));

    // R11: enable receive and read back
    wr(4'd2, 32'h0000_0008);
    rd(4'd2, d);
    chk("R11 rx ctrl", d, 32'h8);
    wr(4'd11, 32'h0000_0008);

    // R5: fill with 17 bytes, last dropped
    for (int i = 0; i < 17; i++) begin
      push(8'(i * 13 + 5));
      if (i == 0) chk("R7 irq on data", {31'b0, irq}, 32'h1);
    end
    rd(4'd13, d);
    chk("R7 raw bit3 set", d, 32'h8);
    rd(4'd9, d);
    chk("R3 peek first", d, exp_stat(8'd5, 1'b1));
    rd(4'd9, d);
    chk("R3 peek again", d, exp_stat(8'd5, 1'b1));
    for (int i = 0; i < 16; i++) begin
      rd(4'd8, d);
      chk("R5 R2 pop order", d, exp_stat(8'(i * 13 + 5), 1'b1));
    end
    rd(4'd8, d);
    chk("R4 pop empty", d, exp_stat(8'h00, 1'b0));
    rd(4'd9, d);
    chk("R4 still empty", d, exp_stat(8'h00, 1'b0));
    chk("R7 irq clear", {31'b0, irq}, 32'h0);
    rd(4'd13, d);
    chk("R7 raw bit3 clear", d, 32'h0);

    // R4/R5: wrap around with interleaved push/pop
    for (int i = 0; i < 20; i++) begin
      push(8'(200 + i));
      rd(4'd8, d);
      chk("R5 wrap order", d, exp_stat(8'(200 + i), 1'b1));
    end

    // R8: transmit
    wr(4'd7, 32'h1234_56A5);
    chk("R8 tx valid", {31'b0, tx_valid}, 32'h1);
    chk("R8 tx byte", {24'h0, tx_byte}, 32'hA5);
    @(negedge clk);
    chk("R8 tx one cycle", {31'b0, tx_valid}, 32'h0);
    rd(4'd13, d);
    chk("R8 raw bits", d, 32'h3);
    rd(4'd7, d);
    chk("R11 tx data", d, 32'h1234_56A5);

    // R9: acknowledge with pending transmit
    wr(4'd12, 32'h3);
    rd(4'd13, d);
    chk("R9 pending ack spares bit0", d, 32'h1);
    rd(4'd12, d);
    chk("R9 ack applied", d, 32'h2);
    wr(4'd12, 32'h1);
    rd(4'd13, d);
    chk("R9 second ack", d, 32'h0);
    rd(4'd12, d);
    chk("R9 ack readback", d, 32'h1);

    // R10: raw/mask sweep
    for (int pi = 0; pi < 6; pi++) begin
      for (int mi = 0; mi < 6; mi++) begin
        p = 32'h0000_00A5 << (pi * 5);
        m = (mi == 0) ? 32'h0 : (32'h1 << (mi * 6 - 1)) | 32'h8;
        wr(4'd13, p);
        wr(4'd11, m);
        rd(4'd14, d);
        chk("R10 masked", d, (p & 32'hFFFF_FFF7) & m);
        chk("R10 irq", {31'b0, irq}, {31'b0, ((p & 32'hFFFF_FFF7) & m) != 0});
      end
    end
    wr(4'd14, 32'hFFFF_FFFF);
    rd(4'd14, d);
    chk("R10 masked write ignored", d, (p & 32'hFFFF_FFF7) & m);
    wr(4'd13, 32'h8);
    rd(4'd13, d);
    chk("R7 raw bit3 write ignored", d, 32'h0);

    // R11: plain storage sweep
    for (int w = 0; w < 15; w++) begin
      if (w == 0 || w == 1 || w == 3 || w == 4 || w == 5 || w == 6 || w == 10) begin
        wr(4'(w), 32'hC3A5_0000 ^ (32'(w) * 32'h0101_1111));
        rd(4'(w), d);
        chk("R11 storage", d, 32'hC3A5_0000 ^ (32'(w) * 32'h0101_1111));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule